// File: doc/BRIEF.md
# Host Receive Endpoint Control and Status

This block keeps the 8-bit control and status byte for one receive endpoint of a USB host controller. Software reads and writes the byte through a simple register port. The transaction engine reports what happened on the bus through single-cycle event inputs: a data packet arrived (possibly flagged with a CRC or bit-stuff error), a STALL handshake came back, a NAK came back, or an attempt ended with no data. A frame tick input marks frame boundaries.

From these events the block keeps its status flags and raises a one-cycle endpoint interrupt. It asks the engine for IN transactions through a request output and sends a one-cycle pulse that clears the data toggle kept elsewhere. Two small engines sit inside. One counts consecutive failed attempts and flags an error on the third. The other times a run of NAKs in frames and halts a bulk endpoint when the run exceeds a programmable limit. The transfer type input sets the meaning of bit 3: a data error on isochronous endpoints, a NAK timeout on bulk endpoints, and always clear on interrupt endpoints.

Top module: `usb_rx_ep_ctl`

## Requirements
- R1: After reset the byte reads 0x00 (with `fifo_full` low) and `in_req`, `dt_clr_pulse` and `ep_irq` are low.
- R2: A write with bit 7 set makes `dt_clr_pulse` high for exactly the cycle after the write. Bit 7 always reads 0.
- R3: Bit 5 (request) takes the written value, and while it is set `in_req` is high, unless the bulk endpoint is halted. Bit 5 clears on the clock edge where a received packet sets bit 0.
- R4: A STALL event sets bit 6 and pulses `ep_irq` in the next cycle. Only a write with bit 6 = 0 clears bit 6. A write with bit 6 = 1 leaves it unchanged.
- R5: For bulk (`xfer_type`=0) and interrupt (`xfer_type`=1) endpoints, the third consecutive no-data event sets bit 2 and pulses `ep_irq`. A write with bit 2 = 0 clears bit 2. For isochronous endpoints (`xfer_type`=2) bit 2 reads 0.
- R6: On an isochronous endpoint, a received packet with its error flag set sets bit 3 together with bit 0. Bit 3 clears whenever bit 0 is cleared by software. A clean packet leaves bit 3 at 0.
- R7: On a bulk endpoint, a NAK event starts a frame count. On the frame tick that brings the count to `nak_limit`, bit 3 sets and `in_req` is forced low until a write with bit 3 = 0. A `nak_limit` of 0 disables the timeout.
- R8: Bit 1 always reads the current value of `fifo_full`, and software writes do not change it.
- R9: A received packet sets bit 0 and pulses `ep_irq` in the next cycle. A write with bit 0 = 0 clears bit 0. A write with bit 0 = 1 never sets it.
- R10: A write with bit 4 (flush) set clears bit 0, and with it the isochronous bit 3. Bit 4 always reads 0.
- R11: The failed-attempt count restarts from zero when a packet is received or when software writes bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ev_pkt_rx | input | 1 | Data packet received |
| ev_pkt_err | input | 1 | Received packet had CRC or bit-stuff error (qualifies ev_pkt_rx) |
| ev_stall_rx | input | 1 | STALL handshake received |
| ev_nak_rx | input | 1 | NAK handshake received |
| ev_no_data | input | 1 | Attempt ended with no data packet |
| frame_tick | input | 1 | One pulse per frame |
| xfer_type | input | 2 | 0 bulk, 1 interrupt, 2 isochronous |
| nak_limit | input | NAK_W | NAK timeout in frames, 0 disables |
| fifo_full | input | 1 | FIFO has no room for another packet |
| in_req | output | 1 | Request an IN transaction |
| dt_clr_pulse | output | 1 | One-cycle data-toggle clear |
| ep_irq | output | 1 | One-cycle endpoint interrupt |

## Verification
The assertions assume that the transaction engine reports at most one bus outcome per cycle. A received packet never coincides with a STALL, NAK or no-data event, and a NAK never lands in the same cycle as a frame tick. They also assume that the transfer type is held steady while a status bit that depends on it is pending. The bench raises exactly one event per cycle, changes `xfer_type` only while all status bits are clear, and keeps `nak_limit` stable during a NAK run.

// File: rtl/usb_rxc_pkg.sv
// Shared types and bit positions for the receive endpoint control block.
// Assumes: the transfer-type code is driven as a two-bit value by the caller.
package usb_rxc_pkg;
    typedef enum logic [1:0] {
        XFER_BULK = 2'd0,
        XFER_INTR = 2'd1,
        XFER_ISO  = 2'd2
    } xfer_e;

    localparam int B_DTCLR  = 7;
    localparam int B_STALL  = 6;
    localparam int B_REQ    = 5;
    localparam int B_FLUSH  = 4;
    localparam int B_AUX    = 3;
    localparam int B_ERR    = 2;
    localparam int B_FULL   = 1;
    localparam int B_RDY    = 0;
endpackage

// File: rtl/usb_rxc_attempts.sv
// Counts consecutive failed receive attempts and flags the one that reaches TRIES.
// Assumes: miss is a single-cycle event; clear has priority over counting.
module usb_rxc_attempts #(
    parameter int TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    input  logic miss,
    output logic hit
);
    localparam int CW = $clog2(TRIES + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIES - 1);

    logic [CW-1:0] cnt_q;

    // Flag the miss that completes the run.
    assign hit = enable && miss && (cnt_q == LAST);

    // Advance the count on each miss, restart on clear, hit or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || clear || hit) begin
            cnt_q <= '0;
        end else if (miss) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/usb_rxc_nak_timer.sv
// Measures a run of NAKs in frames and flags when it reaches the limit.
// Assumes: start and tick do not coincide; a limit of zero disables the timer.
module usb_rxc_nak_timer #(
    parameter int NAK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             clear,
    input  logic             tick,
    input  logic [NAK_W-1:0] limit,
    output logic             timeout
);
    logic             active_q;
    logic [NAK_W-1:0] cnt_q;
    logic [NAK_W-1:0] cnt_nx;

    // Next frame count of the current run.
    assign cnt_nx  = cnt_q + 1'b1;
    assign timeout = enable && active_q && tick && (limit != '0) && (cnt_nx == limit);

    // Track whether a NAK run is open and how many frames it has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!enable || clear || timeout) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (start) active_q <= 1'b1;
            if (active_q && tick) cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/usb_rx_ep_ctl.sv
// Control and status byte for one host receive endpoint.
// Holds the status flags, drives the IN request, the toggle-clear pulse and the
// endpoint interrupt. Assumes one bus outcome per cycle from the transaction engine.
module usb_rx_ep_ctl
    import usb_rxc_pkg::*;
#(
    parameter int NAK_W = 8,
    parameter int TRIES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ev_pkt_rx,
    input  logic             ev_pkt_err,
    input  logic             ev_stall_rx,
    input  logic             ev_nak_rx,
    input  logic             ev_no_data,
    input  logic             frame_tick,
    input  logic [1:0]       xfer_type,
    input  logic [NAK_W-1:0] nak_limit,
    input  logic             fifo_full,
    output logic             in_req,
    output logic             dt_clr_pulse,
    output logic             ep_irq
);
    xfer_e xt;
    logic  is_iso, is_bulk;
    logic  stalled_q, req_q, aux_q, err_q, rdy_q, dt_q, irq_q;
    logic  rdy_clr, err_clr, halted, fail_hit, nak_to;

    // Decode the transfer type.
    assign xt      = xfer_e'(xfer_type);
    assign is_iso  = (xt == XFER_ISO);
    assign is_bulk = (xt == XFER_BULK);

    // Software-side clear strobes.
    assign rdy_clr = reg_wr && (!reg_wdata[B_RDY] || reg_wdata[B_FLUSH]);
    assign err_clr = reg_wr && !reg_wdata[B_ERR];
    assign halted  = is_bulk && aux_q;

    usb_rxc_attempts #(.TRIES(TRIES)) u_attempts (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!is_iso),
        .clear  (ev_pkt_rx || err_clr),
        .miss   (ev_no_data),
        .hit    (fail_hit)
    );

    usb_rxc_nak_timer #(.NAK_W(NAK_W)) u_nak_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (is_bulk),
        .start   (ev_nak_rx),
        .clear   (ev_pkt_rx || ev_stall_rx || halted),
        .tick    (frame_tick),
        .limit   (nak_limit),
        .timeout (nak_to)
    );

    // Status and control flags; hardware set events win over software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled_q <= 1'b0;
            req_q     <= 1'b0;
            aux_q     <= 1'b0;
            err_q     <= 1'b0;
            rdy_q     <= 1'b0;
        end else begin
            if (ev_stall_rx)                        stalled_q <= 1'b1;
            else if (reg_wr && !reg_wdata[B_STALL]) stalled_q <= 1'b0;

            if (ev_pkt_rx)   req_q <= 1'b0;
            else if (reg_wr) req_q <= reg_wdata[B_REQ];

            if (fail_hit)     err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;

            if (ev_pkt_rx)    rdy_q <= 1'b1;
            else if (rdy_clr) rdy_q <= 1'b0;

            unique case (xt)
                XFER_ISO: begin
                    if (ev_pkt_rx)    aux_q <= ev_pkt_err;
                    else if (rdy_clr) aux_q <= 1'b0;
                end
                XFER_BULK: begin
                    if (nak_to)                           aux_q <= 1'b1;
                    else if (reg_wr && !reg_wdata[B_AUX]) aux_q <= 1'b0;
                end
                default: aux_q <= 1'b0;
            endcase
        end
    end

    // One-cycle pulses for the toggle clear and the endpoint interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            dt_q  <= reg_wr && reg_wdata[B_DTCLR];
            irq_q <= ev_pkt_rx || ev_stall_rx || fail_hit;
        end
    end

    // Assemble the read byte and the outputs.
    always_comb begin
        reg_rdata          = '0;
        reg_rdata[B_STALL] = stalled_q;
        reg_rdata[B_REQ]   = req_q;
        reg_rdata[B_AUX]   = aux_q;
        reg_rdata[B_ERR]   = err_q && !is_iso;
        reg_rdata[B_FULL]  = fifo_full;
        reg_rdata[B_RDY]   = rdy_q;
    end

    assign in_req       = req_q && !halted;
    assign dt_clr_pulse = dt_q;
    assign ep_irq       = irq_q;
endmodule

// File: rtl/usb_rx_ep_ctl_chk.sv
// Property checker for the receive endpoint control block, bound to its top.
// Assumes: one bus outcome per cycle and a transfer type held steady.
module usb_rx_ep_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ev_pkt_rx,
    input logic       ev_stall_rx,
    input logic       ev_no_data,
    input logic [1:0] xfer_type,
    input logic       in_req,
    input logic       dt_clr_pulse,
    input logic       ep_irq
);
    AST_DT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7]) |=> dt_clr_pulse); // R2
    AST_DT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dt_clr_pulse |-> $past(reg_wr && reg_wdata[7])); // R2
    AST_PKT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_rx |=> (reg_rdata[0] && !reg_rdata[5])); // R3
    AST_REQ_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[5] && !ev_pkt_rx && xfer_type != 2'd0) |=> in_req); // R3
    AST_STALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall_rx |=> (reg_rdata[6] && ep_irq)); // R4
    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] && !(reg_wr && !reg_wdata[6])) |=> reg_rdata[6]); // R4
    AST_NAKTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == 2'd0 && reg_rdata[3] && !(reg_wr && !reg_wdata[3]))
        |=> (xfer_type != 2'd0 || reg_rdata[3])); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> $past(ev_pkt_rx || ev_stall_rx || ev_no_data)); // R9
endmodule

bind usb_rx_ep_ctl usb_rx_ep_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ev_pkt_rx    (ev_pkt_rx),
    .ev_stall_rx  (ev_stall_rx),
    .ev_no_data   (ev_no_data),
    .xfer_type    (xfer_type),
    .in_req       (in_req),
    .dt_clr_pulse (dt_clr_pulse),
    .ep_irq       (ep_irq)
);

// File: tb/usb_rx_ep_ctl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module usb_rx_ep_ctl_tb;
    localparam int NAK_W = 8;

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       pkt;
        logic       perr;
        logic       stall;
        logic       nak;
        logic       nod;
        logic       tick;
        logic       full;
        logic [7:0] exp_rd;
        logic       exp_req;
        logic       exp_irq;
        logic       exp_dt;
    } vec_t;

    // Bulk endpoint; fields: wr wd pkt perr stall nak nod tick full | rd req irq dt
    localparam vec_t VEC [14] = '{
        '{1'b1, 8'h20, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20, 1'b1,1'b0,1'b0}, // R3 request
        '{1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01, 1'b0,1'b1,1'b0}, // R9 packet
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01, 1'b0,1'b0,1'b0}, // R9 irq ends
        '{1'b1, 8'h81, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01, 1'b0,1'b0,1'b1}, // R2 toggle
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01, 1'b0,1'b0,1'b0}, // R2 single
        '{1'b1, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0,1'b0,1'b0}, // R9 clear
        '{1'b0, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h40, 1'b0,1'b1,1'b0}, // R4 stall
        '{1'b1, 8'h40, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h40, 1'b0,1'b0,1'b0}, // R4 keep
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h42, 1'b0,1'b0,1'b0}, // R8 full
        '{1'b1, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0,1'b0,1'b0}, // R4 clear
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b0,1'b0,1'b0}, // R5 miss 1
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b0,1'b0,1'b0}, // R5 miss 2
        '{1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h04, 1'b0,1'b1,1'b0}, // R5 miss 3
        '{1'b1, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0,1'b0,1'b0}  // R5 clear
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             ev_pkt_rx = 1'b0, ev_pkt_err = 1'b0, ev_stall_rx = 1'b0;
    logic             ev_nak_rx = 1'b0, ev_no_data = 1'b0, frame_tick = 1'b0;
    logic [1:0]       xfer_type = 2'd0;
    logic [NAK_W-1:0] nak_limit = 8'd3;
    logic             fifo_full = 1'b0;
    logic             in_req, dt_clr_pulse, ep_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    usb_rx_ep_ctl #(.NAK_W(NAK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_pkt_rx(ev_pkt_rx), .ev_pkt_err(ev_pkt_err),
        .ev_stall_rx(ev_stall_rx), .ev_nak_rx(ev_nak_rx), .ev_no_data(ev_no_data),
        .frame_tick(frame_tick), .xfer_type(xfer_type), .nak_limit(nak_limit),
        .fifo_full(fifo_full), .in_req(in_req), .dt_clr_pulse(dt_clr_pulse),
        .ep_irq(ep_irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge, return at the next negedge.
    task automatic step(input logic wr, input logic [7:0] wd, input logic pkt,
                        input logic perr, input logic stall, input logic nak,
                        input logic nod, input logic tick);
        reg_wr = wr; reg_wdata = wd; ev_pkt_rx = pkt; ev_pkt_err = perr;
        ev_stall_rx = stall; ev_nak_rx = nak; ev_no_data = nod; frame_tick = tick;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ev_pkt_rx = 1'b0; ev_pkt_err = 1'b0;
        ev_stall_rx = 1'b0; ev_nak_rx = 1'b0; ev_no_data = 1'b0; frame_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);  step(1'b1, d, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0); endtask
    task automatic pkt(input logic e);       step(1'b0, 8'h00, 1'b1,e,1'b0,1'b0,1'b0,1'b0); endtask
    task automatic miss();                   step(1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0); endtask
    task automatic nak();                    step(1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0); endtask
    task automatic tick();                   step(1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outputs", {5'd0, in_req, dt_clr_pulse, ep_irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 14; i++) begin
            fifo_full = VEC[i].full;
            step(VEC[i].wr, VEC[i].wd, VEC[i].pkt, VEC[i].perr, VEC[i].stall,
                 VEC[i].nak, VEC[i].nod, VEC[i].tick);
            chk($sformatf("vec%0d rdata (R2 R3 R4 R5 R8 R9)", i), reg_rdata, VEC[i].exp_rd);
            chk($sformatf("vec%0d outputs (R2 R3 R4 R9)", i),
                {5'd0, in_req, ep_irq, dt_clr_pulse},
                {5'd0, VEC[i].exp_req, VEC[i].exp_irq, VEC[i].exp_dt});
            fifo_full = 1'b0;
        end

        // R9 writing 1 to bit 0 never sets it
        wr(8'h01);
        chk("R9 write one ignored", reg_rdata, 8'h00);

        // R11 software clear restarts the miss count
        miss(); miss(); wr(8'h00); miss(); miss();
        chk("R11 clear restarts count", reg_rdata, 8'h00);
        miss();
        chk("R11 third after clear", reg_rdata, 8'h04);
        wr(8'h00);
        // R11 a packet restarts the miss count
        miss(); miss(); pkt(1'b0); miss(); miss();
        chk("R11 packet restarts count", reg_rdata, 8'h01);
        miss();
        chk("R11 third after packet", reg_rdata, 8'h05);
        wr(8'h00);

        // R5 interrupt endpoint also flags the error
        xfer_type = 2'd1;
        miss(); miss(); miss();
        chk("R5 interrupt error", {7'd0, ep_irq}, 8'h01);
        chk("R5 interrupt rdata", reg_rdata, 8'h04);
        wr(8'h00);

        // R5 isochronous: error reads 0 and no interrupt
        xfer_type = 2'd2;
        miss(); miss(); miss();
        chk("R5 iso error masked", reg_rdata, 8'h00);
        chk("R5 iso no irq", {7'd0, ep_irq}, 8'h00);

        // R6 isochronous data error follows packet-ready
        pkt(1'b1);
        chk("R6 iso error with packet", reg_rdata, 8'h09);
        wr(8'h08);
        chk("R6 clears with packet-ready", reg_rdata, 8'h00);
        pkt(1'b0);
        chk("R6 clean packet", reg_rdata, 8'h01);
        wr(8'h00);

        // R10 flush clears packet-ready and the iso error, reads 0
        pkt(1'b1);
        wr(8'h19);
        chk("R10 flush", reg_rdata, 8'h00);

        // R7 bulk NAK timeout, limit 3
        xfer_type = 2'd0;
        nak_limit = 8'd3;
        wr(8'h20);
        chk("R7 request before NAK", {7'd0, in_req}, 8'h01);
        nak(); tick(); tick();
        chk("R7 not yet timed out", reg_rdata, 8'h20);
        tick();
        chk("R7 timeout flag", reg_rdata, 8'h28);
        chk("R7 halted no request", {7'd0, in_req}, 8'h00);
        tick(); tick();
        chk("R7 stays halted", reg_rdata, 8'h28);
        wr(8'h20);
        chk("R7 released", {reg_rdata[7:1], in_req}, 8'h21);

        // R7 limit 0 disables the timeout
        nak_limit = 8'd0;
        nak();
        for (int k = 0; k < 6; k++) tick();
        chk("R7 limit zero", reg_rdata, 8'h20);
        wr(8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule